// File: doc/BRIEF.md
# Interrupt Mask Register Unit

This block keeps a four-level interrupt enable mask and a summary-mask flag, and it gates incoming priority interrupt requests through them. Software changes the mask only with two 16-bit mask instructions. One clears enable bits by ANDing the mask with the top four bits of a register. The other sets enable bits by ORing them in. A 3-bit register field in the instruction picks the operand source. Field value zero means the accumulator. Any other value means the index register that the surrounding register file returns for that field.

The register file sits outside the block. The unit drives the register field on `reg_sel`. The file returns the four most significant bits of the accumulator and of the addressed index register. In both `acc_top` and `idx_top`, port bit 3 carries register bit 0, the MSB. The unit never writes back to any register or condition indicator. Executing either mask instruction drops the summary-mask override. In the cycle a mask instruction executes, the unit recognizes no request. From the next cycle on, requests pass again under the new mask. The lowest-numbered enabled pending level wins.

Top module: `imr_unit`

## Requirements
- R1: After synchronous reset the mask is 0000, `summary_out` is 1 and `irq_out` is 0.
- R2: A mask instruction is a word with `instr_valid` high and opcode `instr[15:11]` = 10110. Its modifier `instr[7:0]` must be 0x08 (AND) or 0x09 (OR). Any other modifier, any other opcode, or `instr_valid` low leaves the mask and the summary flag unchanged.
- R3: AND-to-mask updates each mask bit i (i = 0..3, level i) to old bit i AND operand bit i. Operand bit i is register bit i counted from the MSB, which is `*_top[3-i]`.
- R4: OR-to-mask updates each mask bit i to old bit i OR operand bit i, with the same bit pairing as R3.
- R5: `reg_sel` always equals `instr[10:8]`. A value of 000 takes the operand from `acc_top`. Any other value takes it from `idx_top`.
- R6: Either mask instruction clears the summary flag on the next edge. `set_summary` sets the flag when no mask instruction executes in the same cycle. If both happen in one cycle, the instruction wins.
- R7: While the summary flag is 1, `irq_out` is 0 whatever the mask and the requests hold.
- R8: When the summary flag is 0 and no mask instruction executes, `irq_out` is 1 exactly when some level has both its request and its mask bit set. `irq_level` is then the lowest such level.
- R9: In a cycle where a mask instruction executes, `mask_busy` is 1 and `irq_out` is 0. In the following cycle, recognition resumes under the updated mask.
- R10: When `irq_out` is 0, `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word: opcode [15:11], register field [10:8], modifier [7:0] |
| acc_top | input | 4 | Accumulator bits 0-3; port bit 3 is register bit 0 |
| idx_top | input | 4 | Bits 0-3 of the index register addressed by `reg_sel` |
| reg_sel | output | 3 | Register field forwarded to the register file |
| set_summary | input | 1 | Sets the summary-mask flag |
| irq_req | input | 4 | Pending request per priority level (bit i = level i) |
| mask_out | output | 4 | Current enable mask (bit i = level i) |
| summary_out | output | 1 | Summary-mask flag |
| mask_busy | output | 1 | A mask instruction executes this cycle |
| irq_out | output | 1 | An enabled request is recognized |
| irq_level | output | 2 | Level of the recognized request |

## Verification
The checker relies on the register file answering `reg_sel` within the same cycle. It also relies on `instr`, `acc_top`, `idx_top`, `irq_req` and `set_summary` being free of X and steady across each rising edge once reset is released. The bench changes every input only on the falling clock edge. Whenever a register field is nonzero, it sets `idx_top` to the value the addressed register would return. It puts a complemented decoy on the source that is not selected, so a wrong operand selection changes the result. Requests are swept over every pattern for every reachable mask. These sweeps keep the requests independent of the instruction stream, which matches what the checker assumes.

// File: rtl/imr_pkg.sv
package imr_pkg;

    localparam int LEVELS   = 4;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int OPC_W    = 5;
    localparam int RSEL_W   = 3;
    localparam int MODF_W   = 8;
    localparam int INSTR_W  = OPC_W + RSEL_W + MODF_W;

    localparam logic [OPC_W-1:0]  OPC_MASKOP = 5'b10110;
    localparam logic [MODF_W-1:0] MODF_AND   = 8'h08;
    localparam logic [MODF_W-1:0] MODF_OR    = 8'h09;
    localparam logic [RSEL_W-1:0] RSEL_ACC   = '0;

    typedef enum logic [1:0] {
        MOP_NONE = 2'd0,
        MOP_AND  = 2'd1,
        MOP_OR   = 2'd2
    } mask_op_e;

    // Field order follows the instruction word, MSB first.
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RSEL_W-1:0] rsel;
        logic [MODF_W-1:0] modf;
    } instr_t;

    typedef struct packed {
        mask_op_e          op;
        logic [RSEL_W-1:0] rsel;
    } dec_t;

    // Register bit i (MSB numbering) sits at port bit LEVELS-1-i.
    function automatic logic [LEVELS-1:0] to_level_order(input logic [LEVELS-1:0] v);
        logic [LEVELS-1:0] r;
        for (int i = 0; i < LEVELS; i++) begin
            r[i] = v[LEVELS-1-i];
        end
        return r;
    endfunction

    function automatic logic next_bit(input mask_op_e op, input logic cur, input logic opb);
        logic r;
        case (op)
            MOP_AND: r = cur & opb;
            MOP_OR:  r = cur | opb;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/imr_decode.sv
module imr_decode
    import imr_pkg::*;
(
    input  logic   valid,
    input  instr_t word,
    output dec_t   dec
);

    logic opc_hit;

    always_comb begin
        opc_hit  = valid && (word.opc == OPC_MASKOP);
        dec.rsel = word.rsel;
        dec.op   = MOP_NONE;
        if (opc_hit) begin
            case (word.modf)
                MODF_AND: dec.op = MOP_AND;
                MODF_OR:  dec.op = MOP_OR;
                default:  dec.op = MOP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/imr_mask_reg.sv
module imr_mask_reg
    import imr_pkg::*;
#(
    parameter int NLVL = LEVELS
) (
    input  logic            clk,
    input  logic            rst,
    input  mask_op_e        op,
    input  logic [NLVL-1:0] opnd_lvl,
    input  logic            set_summary,
    output logic [NLVL-1:0] mask,
    output logic            summary
);

    logic executing;
    assign executing = (op != MOP_NONE);

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask[g] <= 1'b0;
                end else if (executing) begin
                    mask[g] <= next_bit(op, mask[g], opnd_lvl[g]);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            summary <= 1'b1;
        end else if (executing) begin
            summary <= 1'b0;
        end else if (set_summary) begin
            summary <= 1'b1;
        end
    end

endmodule

// File: rtl/imr_prio.sv
module imr_prio #(
    parameter int NLVL = 4,
    localparam int LW  = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic [NLVL-1:0] req,
    input  logic [NLVL-1:0] enable,
    input  logic            block,
    output logic            hit,
    output logic [LW-1:0]   level
);

    logic [NLVL-1:0] live;

    assign live = block ? '0 : (req & enable);

    always_comb begin
        hit   = 1'b0;
        level = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (live[i]) begin
                hit   = 1'b1;
                level = LW'(i);
            end
        end
    end

endmodule

// File: rtl/imr_unit.sv
module imr_unit
    import imr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [LEVELS-1:0]  acc_top,
    input  logic [LEVELS-1:0]  idx_top,
    output logic [RSEL_W-1:0]  reg_sel,
    input  logic               set_summary,
    input  logic [LEVELS-1:0]  irq_req,
    output logic [LEVELS-1:0]  mask_out,
    output logic               summary_out,
    output logic               mask_busy,
    output logic               irq_out,
    output logic [LVL_W-1:0]   irq_level
);

    instr_t            word;
    dec_t              dec;
    logic [LEVELS-1:0] opnd_raw;
    logic [LEVELS-1:0] opnd_lvl;
    logic [LEVELS-1:0] mask_q;
    logic              summary_q;

    assign word = instr_t'(instr);

    imr_decode u_dec (
        .valid (instr_valid),
        .word  (word),
        .dec   (dec)
    );

    assign reg_sel   = dec.rsel;
    assign opnd_raw  = (dec.rsel == RSEL_ACC) ? acc_top : idx_top;
    assign opnd_lvl  = to_level_order(opnd_raw);
    assign mask_busy = (dec.op != MOP_NONE);

    imr_mask_reg #(.NLVL(LEVELS)) u_mreg (
        .clk         (clk),
        .rst         (rst),
        .op          (dec.op),
        .opnd_lvl    (opnd_lvl),
        .set_summary (set_summary),
        .mask        (mask_q),
        .summary     (summary_q)
    );

    imr_prio #(.NLVL(LEVELS)) u_prio (
        .req    (irq_req),
        .enable (mask_q),
        .block  (summary_q | mask_busy),
        .hit    (irq_out),
        .level  (irq_level)
    );

    assign mask_out    = mask_q;
    assign summary_out = summary_q;

endmodule

// File: rtl/imr_unit_chk.sv
module imr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [15:0] instr,
    input logic [3:0]  acc_top,
    input logic [3:0]  idx_top,
    input logic [2:0]  reg_sel,
    input logic        set_summary,
    input logic [3:0]  irq_req,
    input logic [3:0]  mask_out,
    input logic        summary_out,
    input logic        mask_busy,
    input logic        irq_out,
    input logic [1:0]  irq_level
);

    logic       is_and;
    logic       is_or;
    logic [3:0] src;
    logic [3:0] lvl;

    assign is_and = instr_valid && instr[15:11] == 5'b10110 && instr[7:0] == 8'h08;
    assign is_or  = instr_valid && instr[15:11] == 5'b10110 && instr[7:0] == 8'h09;
    assign src    = (instr[10:8] == 3'd0) ? acc_top : idx_top;
    assign lvl    = {src[0], src[1], src[2], src[3]};

    assert_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        !(is_and || is_or) |=> (mask_out == $past(mask_out)));

    assert_and_update_R3: assert property (@(posedge clk) disable iff (rst)
        is_and |=> (mask_out == ($past(mask_out) & $past(lvl))));

    assert_or_update_R4: assert property (@(posedge clk) disable iff (rst)
        is_or |=> (mask_out == ($past(mask_out) | $past(lvl))));

    assert_regsel_R5: assert property (@(posedge clk) disable iff (rst)
        reg_sel == instr[10:8]);

    assert_summary_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (is_and || is_or) |=> !summary_out);

    assert_summary_set_R6: assert property (@(posedge clk) disable iff (rst)
        (set_summary && !(is_and || is_or)) |=> summary_out);

    assert_summary_block_R7: assert property (@(posedge clk) disable iff (rst)
        summary_out |-> !irq_out);

    assert_level_valid_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (irq_req[irq_level] && mask_out[irq_level]));

    assert_busy_block_R9: assert property (@(posedge clk) disable iff (rst)
        (is_and || is_or) |-> (mask_busy && !irq_out));

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_out |-> (irq_level == 2'd0));

endmodule

bind imr_unit imr_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .acc_top     (acc_top),
    .idx_top     (idx_top),
    .reg_sel     (reg_sel),
    .set_summary (set_summary),
    .irq_req     (irq_req),
    .mask_out    (mask_out),
    .summary_out (summary_out),
    .mask_busy   (mask_busy),
    .irq_out     (irq_out),
    .irq_level   (irq_level)
);

// File: tb/imr_unit_tb_top.sv
module imr_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr;
    logic [3:0]  acc_top;
    logic [3:0]  idx_top;
    logic [2:0]  reg_sel;
    logic        set_summary;
    logic [3:0]  irq_req;
    logic [3:0]  mask_out;
    logic        summary_out;
    logic        mask_busy;
    logic        irq_out;
    logic [1:0]  irq_level;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] exp_mask;
    logic       exp_sum;

    always #(CLK_PERIOD/2) clk = ~clk;

    imr_unit dut_i (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr (instr),
        .acc_top (acc_top), .idx_top (idx_top), .reg_sel (reg_sel),
        .set_summary (set_summary), .irq_req (irq_req), .mask_out (mask_out),
        .summary_out (summary_out), .mask_busy (mask_busy), .irq_out (irq_out),
        .irq_level (irq_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] rev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    function automatic logic [15:0] mk(input logic [4:0] opc, input logic [2:0] r, input logic [7:0] m);
        return {opc, r, m};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; instr_valid = 1'b0; instr = '0; acc_top = '0; idx_top = '0;
        set_summary = 1'b0; irq_req = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_mask = 4'b0000;
        exp_sum  = 1'b1;
        #1;
        chk("R1 mask", mask_out, 4'b0000);
        chk("R1 summary", summary_out, 1'b1);
        chk("R1 irq", irq_out, 1'b0);
    endtask

    // Drive one cycle of stimulus, update the model, check results.
    task automatic apply(input logic v, input logic [15:0] iw, input logic [3:0] opnd,
                         input logic ss);
        logic is_and, is_or;
        logic [3:0] lv;
        string tag;
        @(negedge clk);
        instr_valid = v; instr = iw; set_summary = ss;
        if (iw[10:8] == 3'd0) begin acc_top = opnd; idx_top = ~opnd; end
        else begin idx_top = opnd; acc_top = ~opnd; end
        is_and = v && iw[15:11] == 5'b10110 && iw[7:0] == 8'h08;
        is_or  = v && iw[15:11] == 5'b10110 && iw[7:0] == 8'h09;
        #1;
        chk("R5 reg_sel", reg_sel, iw[10:8]);
        chk("R9 busy", mask_busy, is_and || is_or);
        if (is_and || is_or) chk("R9 irq blocked", irq_out, 1'b0);
        lv = rev4(opnd);
        if (is_and) exp_mask = exp_mask & lv;
        if (is_or)  exp_mask = exp_mask | lv;
        if (is_and || is_or) exp_sum = 1'b0;
        else if (ss) exp_sum = 1'b1;
        tag = is_and ? "R3" : (is_or ? "R4" : "R2");
        @(negedge clk);
        instr_valid = 1'b0; set_summary = 1'b0;
        #1;
        chk({tag, " mask"}, mask_out, exp_mask);
        chk({(is_and || is_or) ? "R6" : "R2", " summary"}, summary_out, exp_sum);
    endtask

    task automatic check_irq();
        logic [3:0] live;
        logic       eo;
        logic [1:0] el;
        #1;
        live = exp_sum ? 4'b0000 : (irq_req & exp_mask);
        eo = (live != 0);
        el = 2'd0;
        for (int i = 3; i >= 0; i--) if (live[i]) el = 2'(i);
        chk(exp_sum ? "R7 irq" : "R8 irq", irq_out, eo);
        chk(eo ? "R8 level" : "R10 level", irq_level, el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr = '0; acc_top = '0; idx_top = '0;
        set_summary = 1'b0; irq_req = '0;
        do_reset();

        // R3 worked example: operand 1101 on mask 0111 gives 0101
        apply(1'b1, mk(5'b10110, 3'd0, 8'h09), 4'b0111, 1'b0);
        chk("R4 example mask", mask_out, 4'b1110);
        apply(1'b1, mk(5'b10110, 3'd0, 8'h08), 4'b1101, 1'b0);
        chk("R3 example mask", mask_out, 4'b1010);

        // R3/R4/R5 exhaustive: start mask x operand x op, register field varies
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 16; n++) begin
                for (int op = 0; op < 2; op++) begin
                    do_reset();
                    apply(1'b1, mk(5'b10110, 3'd0, 8'h09), 4'(m), 1'b0);
                    apply(1'b1, mk(5'b10110, 3'(n + op), op ? 8'h09 : 8'h08), 4'(n), 1'b0);
                end
            end
        end

        // R2: foreign modifiers, foreign opcodes, valid low
        do_reset();
        apply(1'b1, mk(5'b10110, 3'd2, 8'h09), 4'b1010, 1'b0);
        for (int md = 0; md < 256; md++) begin
            if (md != 8 && md != 9)
                apply(1'b1, mk(5'b10110, 3'd0, 8'(md)), 4'(md[1] ? 4'b0000 : 4'b1111), 1'b0);
        end
        for (int oc = 0; oc < 32; oc++) begin
            if (oc != 22) begin
                apply(1'b1, mk(5'(oc), 3'd1, 8'h08), 4'b0000, 1'b0);
                apply(1'b1, mk(5'(oc), 3'd1, 8'h09), 4'b1111, 1'b0);
            end
        end
        apply(1'b0, mk(5'b10110, 3'd0, 8'h08), 4'b0000, 1'b0);
        apply(1'b0, mk(5'b10110, 3'd3, 8'h09), 4'b1111, 1'b0);

        // R8/R10 exhaustive: every mask x every request pattern
        for (int m = 0; m < 16; m++) begin
            do_reset();
            apply(1'b1, mk(5'b10110, 3'd0, 8'h09), 4'(m), 1'b0);
            for (int rq = 0; rq < 16; rq++) begin
                @(negedge clk);
                irq_req = 4'(rq);
                check_irq();
            end
        end

        // R6/R7: summary set blocks all; AND with ones clears it keeping mask
        do_reset();
        apply(1'b1, mk(5'b10110, 3'd0, 8'h09), 4'b1111, 1'b0);
        apply(1'b0, 16'h0000, 4'b0000, 1'b1);
        chk("R6 set summary", summary_out, 1'b1);
        for (int rq = 0; rq < 16; rq++) begin
            @(negedge clk);
            irq_req = 4'(rq);
            check_irq();
        end
        // R9: request pending during the instruction, resumes afterwards
        apply(1'b1, mk(5'b10110, 3'd5, 8'h08), 4'b1111, 1'b0);
        chk("R6 mask kept", mask_out, 4'b1111);
        check_irq();
        chk("R9 resume", irq_out, 1'b1);
        // R9: new mask takes effect the next cycle
        apply(1'b1, mk(5'b10110, 3'd0, 8'h08), 4'b0011, 1'b0);
        check_irq();
        chk("R9 new mask level", irq_level, 2'd2);

        // R6: set_summary with a mask instruction in the same cycle
        apply(1'b0, 16'h0000, 4'b0000, 1'b1);
        apply(1'b1, mk(5'b10110, 3'd4, 8'h09), 4'b0000, 1'b1);
        chk("R6 instr wins", summary_out, 1'b0);
        apply(1'b1, mk(5'b10110, 3'd0, 8'h07), 4'b0000, 1'b1);
        chk("R6 set with foreign word", summary_out, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule